// File: doc/BRIEF.md
# USB Bus Reset Detector

This block watches the upstream data line pair of a USB device for a single-ended zero, which is the state with both D+ and D− low. It decides when that state has lasted long enough to be a bus reset rather than the short end-of-packet marker. Once it decides, it raises a reset event for the device controller. The inputs are already synchronised D+ and D− levels, a one-cycle tick per bit time at the configured speed, a speed select and a device-active flag. The device-active flag is high when the device is powered and not suspended.

The block counts bit-time ticks during an unbroken SE0. The qualification threshold is 4 bit times at low speed and 32 bit times at the faster speed. Any non-SE0 line state returns the count to zero, so a shorter SE0 is treated as an end-of-packet and is ignored. At the tick where the count reaches the threshold, the block emits a one-cycle bus-reset pulse. It then holds a reset-active level until the lines leave SE0. When the reset ends, it emits a one-cycle pulse that tells the device controller to clear its stored address and configuration. This returns the device to the attached, unaddressed, unconfigured state, ready to accept a new address command.

Top module: `usb_bus_reset_detector`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, bus_reset_o, reset_active_o and addr_cfg_clr_o are all 0.
- R2: With speed_i=0 (low speed) and dev_active_i=1, bus_reset_o is 1 for the one cycle that follows the clock edge sampling the 4th bit_tick_i of an unbroken SE0 (dp_i=0, dm_i=0). Cycles without bit_tick_i do not advance the count.
- R3: With speed_i=1 (fast speed), the same pulse follows the 32nd tick, and no pulse follows the 31st.
- R4: An SE0 that ends before the threshold produces no pulse. Ticks from separate SE0 intervals are never added together.
- R5: Each unbroken SE0 interval produces at most one bus_reset_o pulse, however long it lasts.
- R6: reset_active_o rises in the same cycle as bus_reset_o. It stays 1 while the lines remain in SE0 and falls in the cycle after the first edge that samples a non-SE0 state.
- R7: addr_cfg_clr_o is a one-cycle pulse in the cycle in which reset_active_o falls, and it occurs at no other time.
- R8: While dev_active_i is 0, the SE0 count is held at zero and no pulse is produced. After dev_active_i rises during an SE0, a full threshold of fresh ticks is needed.
- R9: J (dp_i=1, dm_i=0), K (dp_i=0, dm_i=1) and SE1 (dp_i=1, dm_i=1) all count as non-SE0 states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dp_i | input | 1 | Synchronised D+ level |
| dm_i | input | 1 | Synchronised D− level |
| bit_tick_i | input | 1 | One-cycle strobe per bit time |
| speed_i | input | 1 | 0 selects low speed, 1 selects fast speed |
| dev_active_i | input | 1 | Device is powered and not suspended |
| bus_reset_o | output | 1 | One-cycle pulse when a reset is recognised |
| reset_active_o | output | 1 | High from recognition until SE0 ends |
| addr_cfg_clr_o | output | 1 | One-cycle pulse to clear the address and configuration when the reset ends |

## Verification
Directed runs cover the following cases:
- An SE0 one tick short of the threshold and one exactly at the threshold, at both speeds. This separates an end-of-packet from a reset and shows that the speed select changes the threshold.
- Two short SE0 runs separated by a single J cycle, and an SE0 broken by SE1. Together these show that the count restarts and is not summed across intervals.
- A long SE0 that shows a single pulse.
- An SE0 that begins while the device is inactive, which shows that only ticks after activation count.

A stretch of weighted random line states, ticks, speed changes and activity changes is then compared every cycle against a bench model built from the requirements. This catches errors in the ordering of pulse, level and clear.

// File: rtl/usb_rst_pkg.sv
package usb_rst_pkg;
  typedef enum logic [1:0] {
    LS_SE0 = 2'b00,
    LS_K   = 2'b01,
    LS_J   = 2'b10,
    LS_SE1 = 2'b11
  } line_state_e;

  typedef enum logic {
    SPD_LOW  = 1'b0,
    SPD_FAST = 1'b1
  } speed_e;
endpackage

// File: rtl/usb_line_state.sv
module usb_line_state
  import usb_rst_pkg::*;
(
  input  logic        dp_i,
  input  logic        dm_i,
  output line_state_e state_o,
  output logic        se0_o
);
  always_comb begin
    state_o = line_state_e'({dp_i, dm_i});
    se0_o   = (state_o == LS_SE0);
  end
endmodule

// File: rtl/usb_se0_timer.sv
module usb_se0_timer
  import usb_rst_pkg::*;
#(
  parameter int unsigned LS_MIN_BITS = 4,
  parameter int unsigned HS_MIN_BITS = 32,
  localparam int unsigned SAT_BITS = (HS_MIN_BITS > LS_MIN_BITS) ? HS_MIN_BITS : LS_MIN_BITS,
  localparam int unsigned CNT_W    = $clog2(SAT_BITS + 1)
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   se0_i,
  input  logic   active_i,
  input  logic   tick_i,
  input  speed_e speed_i,
  output logic   qual_o
);
  localparam logic [CNT_W-1:0] LS_THR = CNT_W'(LS_MIN_BITS);
  localparam logic [CNT_W-1:0] HS_THR = CNT_W'(HS_MIN_BITS);
  localparam logic [CNT_W-1:0] SAT    = CNT_W'(SAT_BITS);

  logic [CNT_W-1:0] cnt_q, cnt_inc, thr;
  logic             run;

  always_comb begin
    run     = se0_i && active_i;
    thr     = (speed_i == SPD_FAST) ? HS_THR : LS_THR;
    cnt_inc = (cnt_q == SAT) ? cnt_q : cnt_q + CNT_W'(1);
    qual_o  = run && tick_i && (cnt_inc >= thr);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run)    cnt_q <= '0;
    else if (tick_i)  cnt_q <= cnt_inc;
  end
endmodule

// File: rtl/usb_reset_ctrl.sv
module usb_reset_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic qual_i,
  input  logic se0_i,
  output logic pulse_o,
  output logic active_o,
  output logic clr_o
);
  logic pulse_q, active_q, clr_q, fire;

  // active_q doubles as the one-shot guard for the interval
  assign fire = qual_i && !active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pulse_q  <= 1'b0;
      active_q <= 1'b0;
      clr_q    <= 1'b0;
    end else begin
      pulse_q <= fire;
      clr_q   <= active_q && !se0_i;
      if (fire)        active_q <= 1'b1;
      else if (!se0_i) active_q <= 1'b0;
    end
  end

  assign pulse_o  = pulse_q;
  assign active_o = active_q;
  assign clr_o    = clr_q;
endmodule

// File: rtl/usb_bus_reset_detector.sv
module usb_bus_reset_detector
  import usb_rst_pkg::*;
#(
  parameter int unsigned LS_MIN_BITS = 4,
  parameter int unsigned HS_MIN_BITS = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dp_i,
  input  logic dm_i,
  input  logic bit_tick_i,
  input  logic speed_i,
  input  logic dev_active_i,
  output logic bus_reset_o,
  output logic reset_active_o,
  output logic addr_cfg_clr_o
);
  line_state_e line_state;
  logic        se0, qual;

  usb_line_state u_line (
    .dp_i    (dp_i),
    .dm_i    (dm_i),
    .state_o (line_state),
    .se0_o   (se0)
  );

  usb_se0_timer #(
    .LS_MIN_BITS (LS_MIN_BITS),
    .HS_MIN_BITS (HS_MIN_BITS)
  ) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .se0_i    (se0),
    .active_i (dev_active_i),
    .tick_i   (bit_tick_i),
    .speed_i  (speed_e'(speed_i)),
    .qual_o   (qual)
  );

  usb_reset_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .qual_i   (qual),
    .se0_i    (se0),
    .pulse_o  (bus_reset_o),
    .active_o (reset_active_o),
    .clr_o    (addr_cfg_clr_o)
  );

  logic unused_state;
  assign unused_state = ^line_state;
endmodule

// File: rtl/usb_bus_reset_detector_chk.sv
module usb_bus_reset_detector_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic dp_i,
  input logic dm_i,
  input logic bit_tick_i,
  input logic speed_i,
  input logic dev_active_i,
  input logic bus_reset_o,
  input logic reset_active_o,
  input logic addr_cfg_clr_o
);
  logic se0_s;
  assign se0_s = !dp_i && !dm_i;

  AST_PULSE_ONE_SHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_reset_o |=> !bus_reset_o); // R5
  AST_PULSE_NEEDS_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_reset_o |-> $past(se0_s && bit_tick_i && dev_active_i)); // R2
  AST_PULSE_WITH_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_reset_o |-> reset_active_o); // R6
  AST_ACTIVE_RISE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(reset_active_o) |-> bus_reset_o); // R6
  AST_ACTIVE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reset_active_o && se0_s) |=> reset_active_o); // R6
  AST_CLR_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_cfg_clr_o |-> ($past(reset_active_o) && !reset_active_o)); // R7
  AST_CLR_ONE_SHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_cfg_clr_o |=> !addr_cfg_clr_o); // R7
  AST_INACTIVE_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dev_active_i |=> !bus_reset_o); // R8
  AST_NON_SE0_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !se0_s |=> !bus_reset_o); // R9

  logic unused_spd;
  assign unused_spd = speed_i;
endmodule

bind usb_bus_reset_detector usb_bus_reset_detector_chk chk_i (.*);

// File: tb/usb_bus_reset_detector_tb_top.sv
module usb_bus_reset_detector_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LS_THR = 4;
  localparam int HS_THR = 32;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic dp = 1'b1, dm = 1'b0, tick = 1'b0, spd = 1'b0, act = 1'b1;
  logic bus_reset, reset_active, clr;

  int checks = 0, failures = 0;
  int m_cnt = 0;
  bit m_ra = 0, m_pulse = 0, m_clr = 0;
  bit done = 0;
  int pulses = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_bus_reset_detector dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .dp_i(dp), .dm_i(dm), .bit_tick_i(tick),
    .speed_i(spd), .dev_active_i(act), .bus_reset_o(bus_reset),
    .reset_active_o(reset_active), .addr_cfg_clr_o(clr)
  );

  function automatic int thr_of(bit s);
    return s ? HS_THR : LS_THR;
  endfunction

  task automatic chk(string tag, string what, logic a, logic e);
    checks++;
    if (a !== e) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b @%0t", tag, what, a, e, $time);
    end
  endtask

  task automatic model_edge(bit p, bit m, bit t, bit a, bit s);
    bit se0, fire;
    int nxt;
    se0 = !p && !m;
    nxt = (m_cnt >= HS_THR) ? m_cnt : m_cnt + 1;
    fire = se0 && a && t && (nxt >= thr_of(s)) && !m_ra;
    m_pulse = fire;
    m_clr = m_ra && !se0;
    if (fire) m_ra = 1;
    else if (!se0) m_ra = 0;
    if (!se0 || !a) m_cnt = 0;
    else if (t) m_cnt = nxt;
  endtask

  task automatic step(bit p, bit m, bit t, bit a, bit s, string tag);
    dp = p; dm = m; tick = t; act = a; spd = s;
    @(posedge clk);
    model_edge(p, m, t, a, s);
    #1;
    if (bus_reset) pulses++;
    chk(tag, "bus_reset_o", bus_reset, m_pulse);
    chk(tag, "reset_active_o", reset_active, m_ra);
    chk(tag, "addr_cfg_clr_o", clr, m_clr);
  endtask

  // n ticks of SE0, tick every other cycle
  task automatic se0_ticks(int n, bit a, bit s, string tag);
    for (int i = 0; i < n; i++) begin
      step(0, 0, 0, a, s, tag);
      step(0, 0, 1, a, s, tag);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    #(CLK_PERIOD * 3 + 1);
    chk("R1", "bus_reset_o in reset", bus_reset, 1'b0);
    chk("R1", "reset_active_o in reset", reset_active, 1'b0);
    chk("R1", "addr_cfg_clr_o in reset", clr, 1'b0);
    rst_ni = 1'b1;
    step(0, 0, 1, 1, 0, "R1");

    // R2: low speed threshold; untick cycles do not count
    step(1, 0, 0, 1, 0, "R2");
    for (int i = 0; i < 3; i++) begin
      step(0, 0, 0, 1, 0, "R2");
      step(0, 0, 0, 1, 0, "R2");
      step(0, 0, 1, 1, 0, "R2");
    end
    chk("R2", "no pulse after 3 ticks", bus_reset, 1'b0);
    step(0, 0, 1, 1, 0, "R2");
    chk("R2", "pulse after 4th tick", bus_reset, 1'b1);
    chk("R6", "active with pulse", reset_active, 1'b1);

    // R5: long SE0 keeps one pulse
    pulses = 0;
    se0_ticks(40, 1, 0, "R5");
    chk("R5", "extra pulses in long SE0", logic'(pulses != 0), 1'b0);
    chk("R6", "active held during SE0", reset_active, 1'b1);
    step(1, 0, 0, 1, 0, "R6");
    chk("R6", "active falls after J", reset_active, 1'b0);
    chk("R7", "clear pulse at fall", clr, 1'b1);
    step(1, 0, 0, 1, 0, "R7");
    chk("R7", "clear pulse one cycle", clr, 1'b0);

    // R4: short SE0s, not summed across J
    pulses = 0;
    se0_ticks(3, 1, 0, "R4");
    step(1, 0, 0, 1, 0, "R4");
    se0_ticks(3, 1, 0, "R4");
    step(0, 1, 0, 1, 0, "R9");
    se0_ticks(3, 1, 0, "R4");
    step(1, 1, 1, 1, 0, "R9");
    se0_ticks(3, 1, 0, "R9");
    step(1, 0, 0, 1, 0, "R4");
    chk("R4", "pulses from short SE0s", logic'(pulses != 0), 1'b0);

    // R3: fast speed
    se0_ticks(31, 1, 1, "R3");
    chk("R3", "no pulse after 31 ticks", bus_reset, 1'b0);
    step(0, 0, 1, 1, 1, "R3");
    chk("R3", "pulse after 32nd tick", bus_reset, 1'b1);
    se0_ticks(5, 1, 1, "R3");
    step(1, 0, 0, 1, 1, "R7");
    chk("R7", "clear after fast reset", clr, 1'b1);

    // R8: inactive device
    pulses = 0;
    se0_ticks(40, 0, 0, "R8");
    chk("R8", "pulses while inactive", logic'(pulses != 0), 1'b0);
    se0_ticks(3, 1, 0, "R8");
    chk("R8", "no pulse on 3 fresh ticks", bus_reset, 1'b0);
    step(0, 0, 1, 1, 0, "R8");
    chk("R8", "pulse on 4th fresh tick", bus_reset, 1'b1);
    step(1, 0, 0, 1, 0, "R8");

    // random mix, SE0 favoured
    for (int i = 0; i < 6000; i++) begin
      int unsigned r;
      bit p, m;
      r = $urandom_range(0, 99);
      if (r < 85) begin p = 0; m = 0; end
      else begin p = $urandom_range(0, 1) != 0; m = $urandom_range(0, 1) != 0; end
      step(p, m, $urandom_range(0, 2) == 0, $urandom_range(0, 49) != 0,
           (i / 500) % 2 == 1, "R5");
    end
    finish_run();
  end
endmodule